// File: doc/BRIEF.md
# Dual-Clock FIFO with Mark and Retransmit

This block is a first-in first-out buffer whose write and read sides run on independent clocks. Words go in on the write clock and come out, in order, on the read clock through a registered output. Each clock domain has its own active-low status flags: empty and almost-empty on the read side, and full, almost-full and half-full on the write side. The two almost thresholds are programmable offsets that a separate configuration block supplies.

Two features go beyond a plain FIFO. A write can be masked: the slot is consumed and the write pointer advances, but the stored word is left as it was. On the read side, a mark pulse records the current read position. A later retransmit pulse rewinds the read pointer to that position so the same words can be delivered again. While a mark is held, the write side treats the marked words as still occupied, so they cannot be overwritten before they are replayed.

There are two reset inputs, a master reset and a partial reset. Either one clears all pointers, the output register and the mark. The offsets live outside the block, so the partial reset leaves them as they are.

Top module: `mark_fifo`

## Requirements
- R1: A write takes place on a rising `wr_clk` edge when `wr_en` is high and `full_n` is high; each such write advances the write position by one.
- R2: A write with `wr_keep` low still advances the write position, but the slot keeps its earlier contents, and a later read of that slot returns the earlier word.
- R3: A write attempted while `full_n` is low has no effect: it changes neither the stored words nor the occupancy.
- R4: A read takes place on a rising `rd_clk` edge when `rd_en` is high and `empty_n` is high; the oldest word appears on `rd_data` after that edge. `rd_data` holds its value in every other cycle, and a read attempted while empty changes nothing.
- R5: A `mark` pulse records the read position (a word read in the same cycle counts as after the mark) and arms the retransmit. A `mark` in the same cycle as an effective retransmit is ignored.
- R6: A `retx` pulse while armed returns the read position to the mark. Subsequent reads deliver the earlier words again, in order, until the read position meets the written data. A `retx` while not armed is ignored.
- R7: While armed, the write-side occupancy counts from the mark, so marked words are never overwritten. A new mark at a later position releases the words before it.
- R8: `empty_n` is low exactly when the read-side occupancy is zero. `full_n` is low exactly when the write-side occupancy equals the depth.
- R9: `aempty_n` is low when the read-side occupancy is at most `ae_ofs`. `afull_n` is low when the write-side occupancy is at least depth minus `af_ofs`.
- R10: `half_n` is low when the write-side occupancy is at least half the depth.
- R11: A low level on `mrst_n` or on `prst_n` clears both pointers, zeroes `rd_data` and disarms the mark (mark position zero). Afterwards `empty_n` and `aempty_n` are low, and `full_n`, `half_n` and `afull_n` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| mrst_n | input | 1 | Master reset, asynchronous, active low |
| prst_n | input | 1 | Partial reset, asynchronous, active low |
| wr_en | input | 1 | Write request |
| wr_keep | input | 1 | Store the word (low: advance without storing) |
| wr_data | input | DATA_W | Word to write |
| rd_en | input | 1 | Read request |
| mark | input | 1 | Record the read position and arm retransmit |
| retx | input | 1 | Rewind the read position to the mark |
| ae_ofs | input | ADDR_W+1 | Almost-empty offset |
| af_ofs | input | ADDR_W+1 | Almost-full offset |
| rd_data | output | DATA_W | Registered read word |
| empty_n | output | 1 | Low when empty, read domain |
| aempty_n | output | 1 | Low when almost empty, read domain |
| full_n | output | 1 | Low when full, write domain |
| afull_n | output | 1 | Low when almost full, write domain |
| half_n | output | 1 | Low when at least half full, write domain |

## Verification
The bench builds the block with `ADDR_W` = 4, which gives a depth of 16; the data width stays at 36 and there are two synchronizer stages. At that depth, full, half-full and both almost thresholds (offset 3 each) are reached within a few dozen writes. Pointer wrap and the overwrite of slot zero while a mark is held also occur in a short run. The two clocks are driven in phase, so the crossing latency is fixed and the bench can predict when each flag will settle.

// File: rtl/fifo_rtx_pkg.sv
package fifo_rtx_pkg;
   localparam int MIN_SYNC_STAGES = 2;
   localparam int MIN_ADDR_W      = 2;
   localparam int MAX_ADDR_W      = 16;

   typedef enum logic [1:0] {
      RACT_HOLD   = 2'd0,
      RACT_POP    = 2'd1,
      RACT_REWIND = 2'd2
   } rd_act_e;
endpackage

// File: rtl/fifo_rtx_ram.sv
module fifo_rtx_ram #(
   parameter int DW = 36,
   parameter int AW = 9
) (
   input  logic          wclk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int WORDS = 1 << AW;

   logic [DW-1:0] mem [WORDS];

   always_ff @(posedge wclk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/fifo_rtx_gsync.sv
module fifo_rtx_gsync #(
   parameter int PW     = 10,
   parameter int STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [PW-1:0] gray_in,
   output logic [PW-1:0] bin_out
);
   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         logic [PW-1:0] q;
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) q <= '0;
               else        q <= gray_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) q <= '0;
               else        q <= g_stage[s-1].q;
            end
         end
      end
   endgenerate

   logic [PW-1:0] gq;
   assign gq = g_stage[STAGES-1].q;

   always_comb begin
      logic [PW-1:0] b;
      b[PW-1] = gq[PW-1];
      for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ gq[i];
      bin_out = b;
   end
endmodule

// File: rtl/fifo_rtx_wctl.sv
module fifo_rtx_wctl #(
   parameter int AW     = 9,
   parameter int STAGES = 2
) (
   input  logic          clk,
   input  logic          arst_n,
   input  logic          wr_en,
   input  logic          wr_keep,
   input  logic [AW:0]   af_ofs,
   input  logic [AW:0]   free_gray,
   output logic          rst_n,
   output logic [AW:0]   wptr,
   output logic [AW:0]   wgray,
   output logic          mem_we,
   output logic [AW-1:0] mem_waddr,
   output logic          full_n,
   output logic          afull_n,
   output logic          half_n
);
   localparam int PW = AW + 1;
   localparam logic [AW:0] DEPTH_P = {1'b1, {AW{1'b0}}};

   logic [STAGES-1:0] rsync;
   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) rsync <= '0;
      else         rsync <= {rsync[STAGES-2:0], 1'b1};
   end
   assign rst_n = rsync[STAGES-1];

   logic [AW:0] free_bin;
   fifo_rtx_gsync #(.PW(PW), .STAGES(STAGES)) u_free_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .gray_in (free_gray),
      .bin_out (free_bin)
   );

   logic [AW:0]   lvl;
   logic [AW+1:0] af_sum;
   logic [AW:0]   wnext;
   logic          push;

   assign lvl     = wptr - free_bin;
   assign af_sum  = {1'b0, lvl} + {1'b0, af_ofs};
   assign full_n  = (lvl != DEPTH_P);
   assign afull_n = (af_sum < {1'b0, DEPTH_P});
   assign half_n  = ~(lvl[AW] | lvl[AW-1]);

   assign push      = wr_en & full_n;
   assign wnext     = wptr + PW'(1);
   assign mem_we    = push & wr_keep;
   assign mem_waddr = wptr[AW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         wgray <= '0;
      end else if (push) begin
         wptr  <= wnext;
         wgray <= wnext ^ (wnext >> 1);
      end
   end
endmodule

// File: rtl/fifo_rtx_rctl.sv
module fifo_rtx_rctl
   import fifo_rtx_pkg::*;
#(
   parameter int AW     = 9,
   parameter int STAGES = 2
) (
   input  logic        clk,
   input  logic        arst_n,
   input  logic        rd_en,
   input  logic        mark,
   input  logic        retx,
   input  logic [AW:0] ae_ofs,
   input  logic [AW:0] wgray,
   output logic        rst_n,
   output logic [AW:0] rptr,
   output logic        rd_fire,
   output logic        empty_n,
   output logic        aempty_n,
   output logic [AW:0] mark_ptr,
   output logic        armed,
   output logic [AW:0] free_gray
);
   localparam int PW = AW + 1;

   logic [STAGES-1:0] rsync;
   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) rsync <= '0;
      else         rsync <= {rsync[STAGES-2:0], 1'b1};
   end
   assign rst_n = rsync[STAGES-1];

   logic [AW:0] wbin;
   fifo_rtx_gsync #(.PW(PW), .STAGES(STAGES)) u_wptr_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .gray_in (wgray),
      .bin_out (wbin)
   );

   logic [AW:0] lvl;
   assign lvl      = wbin - rptr;
   assign empty_n  = (lvl != '0);
   assign aempty_n = (lvl > ae_ofs);

   rd_act_e act;
   always_comb begin
      if (retx && armed)        act = RACT_REWIND;
      else if (rd_en && empty_n) act = RACT_POP;
      else                      act = RACT_HOLD;
   end
   assign rd_fire = (act == RACT_POP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rptr     <= '0;
         mark_ptr <= '0;
         armed    <= 1'b0;
      end else begin
         case (act)
            RACT_REWIND: rptr <= mark_ptr;
            RACT_POP:    rptr <= rptr + PW'(1);
            default:     rptr <= rptr;
         endcase
         if (mark && act != RACT_REWIND) begin
            mark_ptr <= rptr;
            armed    <= 1'b1;
         end
      end
   end

   // Released-space pointer: walks one step per cycle toward its target,
   // so its Gray image changes by at most one bit per read clock.
   logic [AW:0] free_q, target, free_nxt;
   assign target   = armed ? mark_ptr : rptr;
   assign free_nxt = free_q + PW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         free_q    <= '0;
         free_gray <= '0;
      end else if (free_q != target) begin
         free_q    <= free_nxt;
         free_gray <= free_nxt ^ (free_nxt >> 1);
      end
   end
endmodule

// File: rtl/mark_fifo.sv
module mark_fifo
   import fifo_rtx_pkg::*;
#(
   parameter int DATA_W      = 36,
   parameter int ADDR_W      = 9,
   parameter int SYNC_STAGES = 2
) (
   input  logic              wr_clk,
   input  logic              rd_clk,
   input  logic              mrst_n,
   input  logic              prst_n,
   input  logic              wr_en,
   input  logic              wr_keep,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic              mark,
   input  logic              retx,
   input  logic [ADDR_W:0]   ae_ofs,
   input  logic [ADDR_W:0]   af_ofs,
   output logic [DATA_W-1:0] rd_data,
   output logic              empty_n,
   output logic              aempty_n,
   output logic              full_n,
   output logic              afull_n,
   output logic              half_n
);
   generate
      if (ADDR_W < MIN_ADDR_W || ADDR_W > MAX_ADDR_W) begin : g_bad_addr_w
         $error("mark_fifo: ADDR_W out of supported range");
      end
      if (SYNC_STAGES < MIN_SYNC_STAGES) begin : g_bad_sync
         $error("mark_fifo: SYNC_STAGES must be at least two");
      end
      if (DATA_W < 1) begin : g_bad_data_w
         $error("mark_fifo: DATA_W must be positive");
      end
   endgenerate

   logic              arst_n;
   logic              wrst_n, rrst_n;
   logic [ADDR_W:0]   wptr, wgray, rptr, mark_ptr, free_gray;
   logic              armed, rd_fire, mem_we;
   logic [ADDR_W-1:0] mem_waddr;
   logic [DATA_W-1:0] ram_q;

   assign arst_n = mrst_n & prst_n;

   fifo_rtx_wctl #(.AW(ADDR_W), .STAGES(SYNC_STAGES)) u_wctl (
      .clk       (wr_clk),
      .arst_n    (arst_n),
      .wr_en     (wr_en),
      .wr_keep   (wr_keep),
      .af_ofs    (af_ofs),
      .free_gray (free_gray),
      .rst_n     (wrst_n),
      .wptr      (wptr),
      .wgray     (wgray),
      .mem_we    (mem_we),
      .mem_waddr (mem_waddr),
      .full_n    (full_n),
      .afull_n   (afull_n),
      .half_n    (half_n)
   );

   fifo_rtx_rctl #(.AW(ADDR_W), .STAGES(SYNC_STAGES)) u_rctl (
      .clk       (rd_clk),
      .arst_n    (arst_n),
      .rd_en     (rd_en),
      .mark      (mark),
      .retx      (retx),
      .ae_ofs    (ae_ofs),
      .wgray     (wgray),
      .rst_n     (rrst_n),
      .rptr      (rptr),
      .rd_fire   (rd_fire),
      .empty_n   (empty_n),
      .aempty_n  (aempty_n),
      .mark_ptr  (mark_ptr),
      .armed     (armed),
      .free_gray (free_gray)
   );

   fifo_rtx_ram #(.DW(DATA_W), .AW(ADDR_W)) u_ram (
      .wclk  (wr_clk),
      .we    (mem_we),
      .waddr (mem_waddr),
      .wdata (wr_data),
      .raddr (rptr[ADDR_W-1:0]),
      .rdata (ram_q)
   );

   always_ff @(posedge rd_clk or negedge rrst_n) begin
      if (!rrst_n)      rd_data <= '0;
      else if (rd_fire) rd_data <= ram_q;
   end
endmodule

// File: rtl/fifo_rtx_chk.sv
module fifo_rtx_chk #(
   parameter int AW = 9,
   parameter int DW = 36
) (
   input logic          wclk,
   input logic          rclk,
   input logic          wrst_n,
   input logic          rrst_n,
   input logic          wr_en,
   input logic          full_n,
   input logic          rd_en,
   input logic          empty_n,
   input logic          retx,
   input logic          armed,
   input logic [AW:0]   wptr,
   input logic [AW:0]   wgray,
   input logic [AW:0]   rptr,
   input logic [AW:0]   mark_ptr,
   input logic [AW:0]   free_gray,
   input logic [DW-1:0] rd_data
);
   assert_wr_step_R1: assert property (@(posedge wclk) disable iff (!wrst_n)
      (wr_en && full_n) |=> (wptr == $past(wptr) + (AW+1)'(1)));

   assert_no_overflow_R3: assert property (@(posedge wclk) disable iff (!wrst_n)
      (wr_en && !full_n) |=> $stable(wptr));

   assert_no_underflow_R4: assert property (@(posedge rclk) disable iff (!rrst_n)
      (rd_en && !empty_n && !(retx && armed)) |=> ($stable(rptr) && $stable(rd_data)));

   assert_out_hold_R4: assert property (@(posedge rclk) disable iff (!rrst_n)
      !rd_en |=> $stable(rd_data));

   assert_rewind_R6: assert property (@(posedge rclk) disable iff (!rrst_n)
      (retx && armed) |=> (rptr == $past(mark_ptr)));

   assert_wgray_step_R8: assert property (@(posedge wclk) disable iff (!wrst_n)
      $countones(wgray ^ $past(wgray)) <= 1);

   assert_fgray_step_R7: assert property (@(posedge rclk) disable iff (!rrst_n)
      $countones(free_gray ^ $past(free_gray)) <= 1);
endmodule

bind mark_fifo fifo_rtx_chk #(.AW(ADDR_W), .DW(DATA_W)) chk_i (
   .wclk      (wr_clk),
   .rclk      (rd_clk),
   .wrst_n    (wrst_n),
   .rrst_n    (rrst_n),
   .wr_en     (wr_en),
   .full_n    (full_n),
   .rd_en     (rd_en),
   .empty_n   (empty_n),
   .retx      (retx),
   .armed     (armed),
   .wptr      (wptr),
   .wgray     (wgray),
   .rptr      (rptr),
   .mark_ptr  (mark_ptr),
   .free_gray (free_gray),
   .rd_data   (rd_data)
);

// File: tb/mark_fifo_tb_top.sv
`timescale 1ns/1ps
module mark_fifo_tb_top;
   localparam int DW = 36;
   localparam int AW = 4;
   localparam int DEPTH = 1 << AW;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic          mrst_n = 1'b0, prst_n = 1'b1;
   logic          wr_en = 1'b0, wr_keep = 1'b1, rd_en = 1'b0, mark = 1'b0, retx = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic [AW:0]   ae_ofs = 5'd3, af_ofs = 5'd3;
   logic [DW-1:0] rd_data;
   logic          empty_n, aempty_n, full_n, afull_n, half_n;

   mark_fifo #(.DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(2)) dut_i (
      .wr_clk(clk), .rd_clk(clk), .mrst_n(mrst_n), .prst_n(prst_n),
      .wr_en(wr_en), .wr_keep(wr_keep), .wr_data(wr_data),
      .rd_en(rd_en), .mark(mark), .retx(retx),
      .ae_ofs(ae_ofs), .af_ofs(af_ofs), .rd_data(rd_data),
      .empty_n(empty_n), .aempty_n(aempty_n), .full_n(full_n),
      .afull_n(afull_n), .half_n(half_n)
   );

   int n_chk = 0, n_fail = 0;

   // entry: [14:10] write attempts, [9:5] read attempts,
   // [4:0] expected {empty_n, aempty_n, half_n, afull_n, full_n} after settling
   localparam logic [14:0] VEC [9] = '{
      {5'd1, 5'd0, 5'b10111},   // level 1
      {5'd3, 5'd0, 5'b11111},   // level 4
      {5'd4, 5'd0, 5'b11011},   // level 8: half
      {5'd5, 5'd0, 5'b11001},   // level 13: almost full
      {5'd3, 5'd0, 5'b11000},   // level 16: full
      {5'd2, 5'd0, 5'b11000},   // both attempts ignored
      {5'd0, 5'd4, 5'b11011},   // level 12
      {5'd0, 5'd9, 5'b10111},   // level 3: almost empty
      {5'd0, 5'd5, 5'b00111}    // two attempts ignored, level 0
   };

   logic [DW-1:0] mq [DEPTH];
   int mhead = 0, mtail = 0, mcount = 0, attempt = 0;
   logic [DW-1:0] exp_q = '0;

   task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_word(input logic [DW-1:0] d, input logic keep);
      @(negedge clk); wr_en = 1'b1; wr_keep = keep; wr_data = d;
      @(negedge clk); wr_en = 1'b0; wr_keep = 1'b1;
   endtask

   task automatic rd_word(output logic [DW-1:0] q);
      @(negedge clk); rd_en = 1'b1;
      @(negedge clk); rd_en = 1'b0; q = rd_data;
   endtask

   task automatic pulse_mark();
      @(negedge clk); mark = 1'b1;
      @(negedge clk); mark = 1'b0;
   endtask

   task automatic pulse_retx();
      @(negedge clk); retx = 1'b1;
      @(negedge clk); retx = 1'b0;
   endtask

   function automatic logic [DW-1:0] flags();
      return DW'({empty_n, aempty_n, half_n, afull_n, full_n});
   endfunction

   logic [DW-1:0] q;

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      settle(4);
      mrst_n = 1'b1;
      settle(6);
      // R11: state right after reset
      check("R11 reset flags", flags(), DW'(5'b00111));
      check("R11 reset rd_data", rd_data, '0);

      // Vector walk: R1 R3 R4 R8 R9 R10
      for (int v = 0; v < 9; v++) begin
         int nw, nr;
         nw = int'(VEC[v][14:10]);
         nr = int'(VEC[v][9:5]);
         for (int k = 0; k < nw; k++) begin
            logic [DW-1:0] d;
            d = 36'hA_0000_0000 | DW'(attempt);
            attempt++;
            wr_word(d, 1'b1);
            if (mcount < DEPTH) begin
               mq[mtail] = d; mtail = (mtail + 1) % DEPTH; mcount++;
            end
         end
         for (int k = 0; k < nr; k++) begin
            rd_word(q);
            if (mcount > 0) begin
               exp_q = mq[mhead]; mhead = (mhead + 1) % DEPTH; mcount--;
            end
            check("R4 read data / R3 ignored", q, exp_q);
         end
         settle(8);
         check("R8 R9 R10 flags vector", flags(), DW'(VEC[v][4:0]));
      end

      // R2: masked write leaves slot 1 holding the word written by attempt 1
      wr_word(36'hB_0000_0001, 1'b1);
      wr_word(36'hB_0000_0002, 1'b0);
      wr_word(36'hB_0000_0003, 1'b1);
      settle(8);
      rd_word(q); check("R2 first", q, 36'hB_0000_0001);
      rd_word(q); check("R2 masked slot", q, 36'hA_0000_0001);
      rd_word(q); check("R2 third", q, 36'hB_0000_0003);
      settle(4);
      check("R8 empty after masked set", DW'(empty_n), '0);

      // R11: partial reset
      wr_word(36'hC_0000_0001, 1'b1);
      wr_word(36'hC_0000_0002, 1'b1);
      settle(8);
      check("R8 not empty", DW'(empty_n), DW'(1));
      @(negedge clk); prst_n = 1'b0;
      @(negedge clk); prst_n = 1'b1;
      settle(6);
      check("R11 partial reset flags", flags(), DW'(5'b00111));
      check("R11 partial reset rd_data", rd_data, '0);
      rd_word(q); check("R4 read while empty", q, '0);

      // R11: master reset
      wr_word(36'hC_0000_0003, 1'b1);
      settle(8);
      rd_word(q); check("R4 read after partial reset", q, 36'hC_0000_0003);
      wr_word(36'hC_0000_0004, 1'b1);
      @(negedge clk); mrst_n = 1'b0;
      @(negedge clk); mrst_n = 1'b1;
      settle(6);
      check("R11 master reset rd_data", rd_data, '0);
      check("R11 master reset flags", flags(), DW'(5'b00111));

      // R6: retransmit without an armed mark is ignored
      wr_word(36'hD_0000_0000, 1'b1);
      wr_word(36'hD_0000_0001, 1'b1);
      settle(8);
      rd_word(q); check("R4 unarmed first", q, 36'hD_0000_0000);
      rd_word(q); check("R4 unarmed second", q, 36'hD_0000_0001);
      pulse_retx();
      settle(4);
      check("R6 unarmed retx empty", DW'(empty_n), '0);
      rd_word(q); check("R6 unarmed retx no data", q, 36'hD_0000_0001);

      // R5 R6: mark and retransmit
      @(negedge clk); mrst_n = 1'b0;
      @(negedge clk); mrst_n = 1'b1;
      settle(6);
      for (int k = 0; k < 6; k++) wr_word(36'hE_0000_0000 | DW'(k), 1'b1);
      settle(8);
      rd_word(q); check("R4 W0", q, 36'hE_0000_0000);
      pulse_mark();
      for (int k = 1; k < 4; k++) begin
         rd_word(q); check("R5 after mark", q, 36'hE_0000_0000 | DW'(k));
      end
      pulse_retx();
      for (int k = 1; k < 6; k++) begin
         rd_word(q); check("R6 replay", q, 36'hE_0000_0000 | DW'(k));
      end
      rd_word(q); check("R6 replay stops at write data", q, 36'hE_0000_0005);
      check("R6 empty after replay", DW'(empty_n), '0);

      // R7: marked words hold their space
      for (int k = 0; k < 11; k++) wr_word(36'hF_0000_0000 | DW'(k), 1'b1);
      check("R7 full counted from mark", DW'(full_n), '0);
      wr_word(36'hF_0000_0011, 1'b1);
      settle(8);
      check("R3 R7 still full", DW'(full_n), '0);
      check("R8 read side not empty", DW'(empty_n), DW'(1));
      pulse_mark();
      settle(8);
      check("R7 new mark releases", flags(), DW'(5'b11011));
      for (int k = 0; k < 11; k++) begin
         rd_word(q); check("R7 order kept", q, 36'hF_0000_0000 | DW'(k));
      end
      settle(4);
      check("R3 extra write dropped", DW'(empty_n), '0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule